// File: doc/BRIEF.md
# I2C Target Address Receiver

This block is the address-phase front end of an I2C target. It samples the bus clock and data lines through two-flop synchronizers and finds start and stop conditions in the synchronized samples. After a start it shifts in one address byte: seven address bits, most significant first, and then the direction bit. It compares the address with a programmable own address and with the general-call address.

On a match the block pulls the data line low for the ninth (acknowledge) clock. At the falling edge of that clock it raises an interrupt request and clears its pending flag. While the pending flag is 0 it holds the clock line low, which stretches the clock until software writes a one-cycle release strobe. On a mismatch it leaves both lines alone and disregards the bus until the next start. Both bus pins are open-drain: the block only drives each pin low through an enable, and it reads the line level back on a separate input.

Top module: `i2c_addr_target`

## Requirements
- R1: After reset both drive-low enables are 0, the interrupt request is 0, the pending flag is 1, and the direction and general-call status outputs are 0.
- R2: The first eight SCL rising edges after a start sample the address bits A6 down to A0 (MSB first) and then the direction bit (1 = read, 0 = write). After an acknowledged address, dirBit shows the direction bit.
- R3: When the received address equals ownAddr, sdaDriveLow is 1 from the falling edge of the eighth clock to the falling edge of the ninth clock, whatever the direction bit.
- R4: At the falling edge of the ninth clock of an acknowledged address, irqReq goes to 1 and pendFlag goes to 0.
- R5: While pendFlag is 0, sclDriveLow stays at 1, with no time limit.
- R6: A one-cycle releaseStrobe sets pendFlag to 1, so that irqReq and sclDriveLow are 0 from the next cycle on.
- R7: Address 7'b0000000 with direction 0 is acknowledged and sets genCallHit to 1. With direction 1 it is not acknowledged, unless it equals ownAddr. genCallHit is never 1 while dirBit is 1.
- R8: On a mismatching address, sdaDriveLow and irqReq stay 0. Later SCL clocks are disregarded until the next start, even clocks that carry a matching address.
- R9: A repeated start (SDA falling while SCL is high) at any point restarts address reception at A6.
- R10: A stop (SDA rising while SCL is high) ends reception. Clocks that follow without a new start are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | SCL line level as seen on the pin |
| sdaIn | input | 1 | SDA line level as seen on the pin |
| ownAddr | input | ADDR_W | Programmed own target address |
| releaseStrobe | input | 1 | One-cycle software pulse that sets the pending flag |
| sclDriveLow | output | 1 | Pull the SCL pin low (clock stretch) |
| sdaDriveLow | output | 1 | Pull the SDA pin low (acknowledge) |
| irqReq | output | 1 | Interrupt request after an acknowledged address |
| pendFlag | output | 1 | Pending flag; 0 while waiting for software |
| dirBit | output | 1 | Direction bit of the last acknowledged address |
| genCallHit | output | 1 | Last acknowledged address was a general call |

## Verification
The bench sends the programmed address with both directions. It also sends the bit-reversed form of that address, which can only be refused if bits are taken MSB first. The general-call address is sent with write and with read, and that pair separates a plain zero compare from the direction-qualified one. A mismatching address followed by the matching pattern clocked without a start shows that the block really disregards the bus. A start that cuts an address short, and clocks sent after a stop, show that start and stop reset the bit position. Throughout these patterns a behavioural model is compared with every output on every clock, so the exact cycle of each acknowledge edge, interrupt and clock stretch is checked as well as the final values.

// File: rtl/i2c_addr_pkg.sv
package i2c_addr_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_ACK,
    PH_HOLD,
    PH_SKIP
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearBits;
    logic shiftBit;
    logic latchResult;
  } dpCtrl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
    logic byteDone;
    logic ownHit;
    logic gcHit;
  } dpStat_t;

endpackage

// File: rtl/i2c_addr_sync.sv
module i2c_addr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic syncOut,
  output logic prevOut
);
  localparam int PIPE_W = STAGES + 1;

  logic [PIPE_W-1:0] pipe;

  always_ff @(posedge clk) begin
    if (!rstN) pipe <= '1;  // idle bus level
    else       pipe <= {pipe[PIPE_W-2:0], din};
  end

  assign syncOut = pipe[STAGES-1];
  assign prevOut = pipe[STAGES];
endmodule

// File: rtl/i2c_addr_datapath.sv
module i2c_addr_datapath
  import i2c_addr_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [ADDR_W-1:0] ownAddr,
  input  dpCtrl_t           ctrl,
  output dpStat_t           stat,
  output logic              dirBit,
  output logic              genCallHit
);
  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam int LINES  = 2;  // index 0 = SCL, 1 = SDA

  logic [LINES-1:0] lineRaw, lineNow, linePrev;
  assign lineRaw = {sdaIn, sclIn};

  for (genvar g = 0; g < LINES; g++) begin : gSync
    i2c_addr_sync #(.STAGES(SYNC_STAGES)) uSync (
      .clk    (clk),
      .rstN   (rstN),
      .din    (lineRaw[g]),
      .syncOut(lineNow[g]),
      .prevOut(linePrev[g])
    );
  end

  logic sclNow, sclPrev, sdaNow, sdaPrev;
  assign sclNow  = lineNow[0];
  assign sclPrev = linePrev[0];
  assign sdaNow  = lineNow[1];
  assign sdaPrev = linePrev[1];

  logic [BYTE_W-1:0] shiftReg;
  logic [CNT_W-1:0]  bitCnt;
  logic [ADDR_W-1:0] rxAddr;
  logic              rxDir;

  assign rxAddr = shiftReg[BYTE_W-1:1];
  assign rxDir  = shiftReg[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (ctrl.clearBits) begin
      bitCnt   <= '0;
    end else if (ctrl.shiftBit) begin
      shiftReg <= {shiftReg[BYTE_W-2:0], sdaNow};
      bitCnt   <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirBit     <= 1'b0;
      genCallHit <= 1'b0;
    end else if (ctrl.latchResult) begin
      dirBit     <= rxDir;
      genCallHit <= (rxAddr == '0) && !rxDir;
    end
  end

  always_comb begin
    stat.sclRise   = sclNow && !sclPrev;
    stat.sclFall   = !sclNow && sclPrev;
    stat.startSeen = sclNow && sclPrev && sdaPrev && !sdaNow;
    stat.stopSeen  = sclNow && sclPrev && !sdaPrev && sdaNow;
    stat.byteDone  = (bitCnt == CNT_FULL);
    stat.ownHit    = (rxAddr == ownAddr);
    stat.gcHit     = (rxAddr == '0) && !rxDir;
  end
endmodule

// File: rtl/i2c_addr_ctrl.sv
module i2c_addr_ctrl
  import i2c_addr_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  dpStat_t stat,
  input  logic    releaseStrobe,
  output dpCtrl_t ctrl,
  output logic    sclDriveLow,
  output logic    sdaDriveLow,
  output logic    irqReq,
  output logic    pendFlag
);
  phase_t phase;
  logic   busEvent, hit, ninthFall;

  assign busEvent  = stat.startSeen || stat.stopSeen;
  assign hit       = stat.ownHit || stat.gcHit;
  assign ninthFall = (phase == PH_ACK) && stat.sclFall && !busEvent;

  always_comb begin
    ctrl.clearBits   = stat.startSeen;
    ctrl.shiftBit    = (phase == PH_ADDR) && stat.sclRise && !stat.byteDone && !busEvent;
    ctrl.latchResult = (phase == PH_ADDR) && stat.sclFall && stat.byteDone && hit && !busEvent;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase       <= PH_IDLE;
      sdaDriveLow <= 1'b0;
    end else if (stat.startSeen) begin
      phase       <= PH_ADDR;
      sdaDriveLow <= 1'b0;
    end else if (stat.stopSeen) begin
      phase       <= PH_IDLE;
      sdaDriveLow <= 1'b0;
    end else begin
      unique case (phase)
        PH_ADDR: if (stat.sclFall && stat.byteDone) begin
          if (hit) begin
            phase       <= PH_ACK;
            sdaDriveLow <= 1'b1;
          end else begin
            phase <= PH_SKIP;
          end
        end
        PH_ACK: if (stat.sclFall) begin
          phase       <= PH_HOLD;
          sdaDriveLow <= 1'b0;
        end
        PH_HOLD: if (releaseStrobe) phase <= PH_SKIP;
        default: ;
      endcase
    end
  end

  // pending flag and interrupt: the ninth falling edge wins over a release
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendFlag <= 1'b1;
      irqReq   <= 1'b0;
    end else if (ninthFall) begin
      pendFlag <= 1'b0;
      irqReq   <= 1'b1;
    end else if (releaseStrobe) begin
      pendFlag <= 1'b1;
      irqReq   <= 1'b0;
    end
  end

  assign sclDriveLow = !pendFlag;
endmodule

// File: rtl/i2c_addr_target.sv
module i2c_addr_target
  import i2c_addr_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              releaseStrobe,
  output logic              sclDriveLow,
  output logic              sdaDriveLow,
  output logic              irqReq,
  output logic              pendFlag,
  output logic              dirBit,
  output logic              genCallHit
);
  dpCtrl_t ctrl;
  dpStat_t stat;

  i2c_addr_datapath #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .ownAddr   (ownAddr),
    .ctrl      (ctrl),
    .stat      (stat),
    .dirBit    (dirBit),
    .genCallHit(genCallHit)
  );

  i2c_addr_ctrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .stat         (stat),
    .releaseStrobe(releaseStrobe),
    .ctrl         (ctrl),
    .sclDriveLow  (sclDriveLow),
    .sdaDriveLow  (sdaDriveLow),
    .irqReq       (irqReq),
    .pendFlag     (pendFlag)
  );
endmodule

// File: rtl/i2c_addr_target_chk.sv
module i2c_addr_target_chk (
  input logic clk,
  input logic rstN,
  input logic releaseStrobe,
  input logic sclDriveLow,
  input logic sdaDriveLow,
  input logic irqReq,
  input logic pendFlag,
  input logic dirBit,
  input logic genCallHit
);
  // R4: a new request follows an acknowledge and comes with the flag cleared
  assert_irq_after_ack_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReq) |-> ($past(sdaDriveLow) && !pendFlag));

  // R5: the clock stays stretched until software releases it
  assert_stretch_held_R5: assert property (@(posedge clk) disable iff (!rstN)
    (sclDriveLow && !releaseStrobe) |=> sclDriveLow);

  // R6: a release outside the acknowledge clock drops the request and the stretch
  assert_release_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (releaseStrobe && !sdaDriveLow) |=> (!irqReq && !sclDriveLow));

  // R7: general call is only reported for a write
  assert_gc_write_only_R7: assert property (@(posedge clk) disable iff (!rstN)
    genCallHit |-> !dirBit);
endmodule

bind i2c_addr_target i2c_addr_target_chk uChk (
  .clk          (clk),
  .rstN         (rstN),
  .releaseStrobe(releaseStrobe),
  .sclDriveLow  (sclDriveLow),
  .sdaDriveLow  (sdaDriveLow),
  .irqReq       (irqReq),
  .pendFlag     (pendFlag),
  .dirBit       (dirBit),
  .genCallHit   (genCallHit)
);

// File: tb/tb_i2c_addr_target.sv
`timescale 1ns/1ps
module tb_i2c_addr_target;
  localparam int H = 6;  // half bit time in clocks

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic       rstN = 1'b0;
  logic       mScl = 1'b1, mSda = 1'b1;
  logic [6:0] ownAddr = 7'h5A;
  logic       rel = 1'b0;
  logic       sclDriveLow, sdaDriveLow, irqReq, pendFlag, dirBit, genCallHit;
  logic       sclLine, sdaLine;

  assign sclLine = mScl & ~sclDriveLow;
  assign sdaLine = mSda & ~sdaDriveLow;

  i2c_addr_target dut (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine),
    .ownAddr(ownAddr), .releaseStrobe(rel),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow),
    .irqReq(irqReq), .pendFlag(pendFlag), .dirBit(dirBit), .genCallHit(genCallHit)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mdSt = 0;  // 0 idle, 1 address, 2 acknowledge, 3 hold, 4 skip
  int mdCnt = 0, mdShift = 0;
  int mdPend = 1, mdIrq = 0, mdSdaLow = 0, mdDir = 0, mdGc = 0;
  int sclH[3] = '{1, 1, 1};
  int sdaH[3] = '{1, 1, 1};

  always @(posedge clk) begin
    if (!rstN) begin
      mdSt = 0; mdCnt = 0; mdShift = 0; mdPend = 1; mdIrq = 0;
      mdSdaLow = 0; mdDir = 0; mdGc = 0;
      sclH = '{1, 1, 1}; sdaH = '{1, 1, 1};
    end else begin
      int rise, fall, sta, sto, adr, d, hit, full, st0;
      rise = sclH[1] & ~sclH[2] & 1;
      fall = ~sclH[1] & sclH[2] & 1;
      sta  = sclH[1] & sclH[2] & sdaH[2] & ~sdaH[1] & 1;
      sto  = sclH[1] & sclH[2] & ~sdaH[2] & sdaH[1] & 1;
      adr  = mdShift >> 1;
      d    = mdShift & 1;
      hit  = (adr == int'(ownAddr)) || (adr == 0 && d == 0);
      full = (mdCnt == 8);
      st0  = mdSt;
      if (st0 == 2 && fall && !sta && !sto) begin mdIrq = 0 + 1; mdPend = 0; end
      else if (rel) begin mdPend = 1; mdIrq = 0; end
      if (sta) begin mdSt = 1; mdCnt = 0; mdSdaLow = 0; end
      else if (sto) begin mdSt = 0; mdSdaLow = 0; end
      else if (st0 == 1) begin
        if (rise && !full) begin mdShift = ((mdShift << 1) | sdaH[1]) & 255; mdCnt++; end
        else if (fall && full) begin
          if (hit) begin mdSt = 2; mdSdaLow = 1; mdDir = d; mdGc = (adr == 0 && d == 0); end
          else mdSt = 4;
        end
      end else if (st0 == 2 && fall) begin mdSt = 3; mdSdaLow = 0; end
      else if (st0 == 3 && rel) mdSt = 4;
      sclH[2] = sclH[1]; sclH[1] = sclH[0]; sclH[0] = int'(sclLine);
      sdaH[2] = sdaH[1]; sdaH[1] = sdaH[0]; sdaH[0] = int'(sdaLine);
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R3 sdaDriveLow vs model", int'(sdaDriveLow), mdSdaLow);
      check("R4 irqReq vs model", int'(irqReq), mdIrq);
      check("R5 sclDriveLow vs model", int'(sclDriveLow), 1 - mdPend);
      check("R6 pendFlag vs model", int'(pendFlag), mdPend);
      check("R2 dirBit vs model", int'(dirBit), mdDir);
      check("R7 genCallHit vs model", int'(genCallHit), mdGc);
    end
  end

  // ---------------- bus master tasks ----------------
  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sclHigh();
    mScl = 1'b1;
    @(negedge clk);
    while (!sclLine) @(negedge clk);
    waitClk(H);
  endtask

  task automatic busStart();
    mSda = 1'b1; waitClk(H);
    sclHigh();
    mSda = 1'b0; waitClk(H);
    mScl = 1'b0; waitClk(H);
  endtask

  task automatic busStop();
    mSda = 1'b0; waitClk(H);
    sclHigh();
    mSda = 1'b1; waitClk(H);
  endtask

  task automatic sendBit(input logic b);
    mSda = b; waitClk(H);
    sclHigh();
    mScl = 1'b0; waitClk(H);
  endtask

  // eight bits MSB first, then the acknowledge clock; ack = 1 if SDA pulled low
  task automatic sendByte(input logic [7:0] by, output logic ack);
    for (int i = 7; i >= 0; i--) sendBit(by[i]);
    mSda = 1'b1; waitClk(H);
    mScl = 1'b1;
    @(negedge clk);
    while (!sclLine) @(negedge clk);
    waitClk(H);
    ack = ~sdaLine;
    mScl = 1'b0; waitClk(H);
  endtask

  task automatic pulseRelease();
    rel = 1'b1; @(negedge clk); rel = 1'b0;
  endtask

  // address phase that must be acknowledged, then software release
  task automatic ackedAddr(input logic [6:0] a, input logic d, input logic expGc, input string tag);
    logic ack;
    busStart();
    sendByte({a, d}, ack);
    check({tag, " acknowledge seen"}, int'(ack), 1);
    waitClk(4);
    check("R4 irqReq after ninth clock", int'(irqReq), 1);
    check("R4 pendFlag cleared", int'(pendFlag), 0);
    check("R2 dirBit latched", int'(dirBit), int'(d));
    check("R7 genCallHit latched", int'(genCallHit), int'(expGc));
    waitClk(60);
    check("R5 SCL still stretched", int'(sclLine), 0);
    pulseRelease();
    check("R6 irqReq cleared by release", int'(irqReq), 0);
    check("R6 SCL released", int'(sclDriveLow), 0);
    busStop();
  endtask

  task automatic refusedAddr(input logic [7:0] by, input string tag);
    logic ack;
    busStart();
    sendByte(by, ack);
    check({tag, " no acknowledge"}, int'(ack), 0);
    waitClk(4);
    check({tag, " no interrupt"}, int'(irqReq), 0);
    busStop();
  endtask

  initial begin
    logic ack;
    waitClk(3);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset sclDriveLow", int'(sclDriveLow), 0);
    check("R1 reset sdaDriveLow", int'(sdaDriveLow), 0);
    check("R1 reset irqReq", int'(irqReq), 0);
    check("R1 reset pendFlag", int'(pendFlag), 1);
    check("R1 reset status", int'({dirBit, genCallHit}), 0);

    ackedAddr(7'h5A, 1'b0, 1'b0, "R3 own write");
    ackedAddr(7'h5A, 1'b1, 1'b0, "R3 own read");
    refusedAddr({7'h2D, 1'b0}, "R2 bit-reversed address");
    ackedAddr(7'h00, 1'b0, 1'b1, "R7 general call write");
    refusedAddr({7'h00, 1'b1}, "R7 general call read");

    // R8: mismatch, then the matching pattern without a start
    busStart();
    sendByte({7'h33, 1'b0}, ack);
    check("R8 mismatch no acknowledge", int'(ack), 0);
    sendByte({7'h5A, 1'b0}, ack);
    check("R8 later clocks ignored", int'(ack), 0);
    check("R8 no interrupt", int'(irqReq), 0);
    busStop();

    // R9: repeated start after three bits
    busStart();
    sendBit(1'b0); sendBit(1'b1); sendBit(1'b1);
    ackedAddr(7'h5A, 1'b0, 1'b0, "R9 repeated start");

    // R10: clocks after a stop without a start
    busStart();
    sendBit(1'b1); sendBit(1'b0);
    busStop();
    mScl = 1'b0; waitClk(H);
    sendByte({7'h5A, 1'b0}, ack);
    check("R10 no acknowledge after stop", int'(ack), 0);
    check("R10 no interrupt after stop", int'(irqReq), 0);
    busStop();

    waitClk(10);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule